// File: doc/BRIEF.md
# Prioritised Interrupt Vector Resolver

This block decides which interrupt the processor core services next and supplies the 16-bit address of that source's vector. Fourteen peripheral sources arrive as pending flags with matching local enables; the external interrupt pin arrives raw and is qualified inside the block. The pin can be qualified either as active-low level or as a latched falling edge. Three non-maskable requests (illegal opcode trap, software interrupt and the pseudo non-maskable pin request) bypass the core's I mask. The core's two mask bits gate the requests: I gates all maskable sources and X gates only the pseudo non-maskable pin.

A 4-bit priority-select register can lift any one maskable source above all the others. The core may change it only while the I bit is set, which keeps the order from shifting under an interrupt that is already being taken. The result is registered. Every cycle the block presents a valid flag, a source identifier and a vector for the core's exception sequencer to use. The core pulses an acknowledge when it accepts the pin interrupt, and this clears a latched edge.

Top module: `intr_vector_resolver`

## Requirements
- R1: Maskable source identifiers, from highest to lowest default priority: 0 pin, 1 real-time tick, 2–4 input captures 1–3, 5–8 output compares 1–4, 9 capture-4/compare-5, 10 timer overflow, 11 accumulator overflow, 12 accumulator edge, 13 SPI, 14 SCI. Peripheral source k (1..14) uses bit k-1 of `periph_pend` and of `periph_en`. With no promotion in effect, the lowest-numbered active maskable request wins.
- R2: A peripheral request is active only when its pending and enable bits are both 1 and `i_mask` is 0. The pin request has no local enable and is also blocked while `i_mask` is 1.
- R3: The vector for maskable identifier n is 0xFFF2 − 2n, so it runs from 0xFFF2 for the pin down to 0xFFD6 for SCI.
- R4: The non-maskable requests outrank every maskable request and ignore `i_mask`. Their order is illegal opcode (id 17, 0xFFF8), then software interrupt (id 16, 0xFFF6), then pseudo non-maskable pin (id 15, 0xFFF4). The pin request counts only while `x_mask` is 0.
- R5: The priority-select code promotes one source above all other maskable sources. Codes 0–4 select ids 10–14, and codes 6–15 select ids 0–9 (id = code − 6).
- R6: `psel_q` resets to 0101. Code 0101 selects no source, so the default order of R1 applies.
- R7: A write (`psel_we`) loads `psel_wdata` into `psel_q` only when `i_mask` is 1. A write while `i_mask` is 0 leaves `psel_q` unchanged.
- R8: With `irq_edge_sel` at 0, the pin requests for every cycle in which `irq_n` is 0.
- R9: With `irq_edge_sel` at 1, a high-to-low transition of `irq_n` raises the pin request. The request stays until `irq_ack` is sampled at 1, even if the pin has returned high. A pin held low without a new transition does not raise the request again.
- R10: The grant outputs are registered and reflect the inputs sampled at the preceding clock edge. When nothing wins, `grant_valid`, `grant_src` and `grant_vec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | External interrupt pin, active low, synchronous to clk |
| irq_edge_sel | input | 1 | 0 = level qualification, 1 = falling-edge qualification |
| irq_ack | input | 1 | Clears a latched pin edge |
| periph_pend | input | 14 | Peripheral pending flags, bit k-1 = source id k |
| periph_en | input | 14 | Peripheral local enables, same bit order |
| i_mask | input | 1 | Core I bit: masks maskable sources, unlocks priority select |
| x_mask | input | 1 | Core X bit: masks the pseudo non-maskable pin request |
| xirq_req | input | 1 | Pseudo non-maskable pin request |
| swi_req | input | 1 | Software interrupt request |
| illop_req | input | 1 | Illegal opcode trap request |
| psel_we | input | 1 | Priority-select write strobe |
| psel_wdata | input | 4 | Priority-select write data |
| psel_q | output | 4 | Current priority-select code |
| grant_valid | output | 1 | A source has won |
| grant_src | output | 5 | Winning source identifier |
| grant_vec | output | 16 | Vector address of the winner |

## Verification
Each grant is due one clock edge after the inputs that produce it. A priority-select write changes `psel_q` at the edge that samples the write, but it reorders grants only from the following edge, because arbitration uses the stored code. The bench drives every input a short time after a rising edge and computes the expected grant and code from its model state before that edge. It then updates the model state and compares all outputs a short time after the next edge. In edge mode, one step with a falling pin grants the pin at once. Later steps show it held until the step after an acknowledge.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int NUM_MASKABLE = 15;
    localparam int NUM_PERIPH   = NUM_MASKABLE - 1;
    localparam int SRC_W        = 5;
    localparam int VEC_W        = 16;
    localparam int PSEL_W       = 4;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFF2;

    typedef enum logic [SRC_W-1:0] {
        SRC_IRQ    = 5'd0,
        SRC_RTI    = 5'd1,
        SRC_IC1    = 5'd2,
        SRC_IC2    = 5'd3,
        SRC_IC3    = 5'd4,
        SRC_OC1    = 5'd5,
        SRC_OC2    = 5'd6,
        SRC_OC3    = 5'd7,
        SRC_OC4    = 5'd8,
        SRC_OC5    = 5'd9,
        SRC_TOV    = 5'd10,
        SRC_PAOV   = 5'd11,
        SRC_PAEDGE = 5'd12,
        SRC_SPI    = 5'd13,
        SRC_SCI    = 5'd14,
        SRC_XIRQ   = 5'd15,
        SRC_SWI    = 5'd16,
        SRC_ILLOP  = 5'd17
    } src_e;

    typedef struct packed {
        logic             valid;
        src_e             src;
        logic [VEC_W-1:0] vec;
    } grant_t;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } promo_t;

    function automatic promo_t decode_psel(input logic [PSEL_W-1:0] code);
        promo_t r;
        r.hit = 1'b1;
        if (code < 4'd5) begin
            r.idx = code + 4'd10;
        end else if (code == 4'd5) begin
            r.hit = 1'b0;
            r.idx = 4'd0;
        end else begin
            r.idx = code - 4'd6;
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] vector_of(input src_e s);
        logic [VEC_W-1:0] n;
        n = {11'd0, s};
        if (s <= SRC_SCI)
            return VEC_TOP - (n << 1);
        else
            return VEC_TOP + ((n - 16'd14) << 1);
    endfunction

endpackage

// File: rtl/irq_qualifier.sv
module irq_qualifier (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic edge_sel,
    input  logic ack,
    output logic irq_req
);
    logic pin_prev;
    logic edge_hold;
    logic fall_now;

    assign fall_now = pin_prev & ~irq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev  <= 1'b1;
            edge_hold <= 1'b0;
        end else begin
            pin_prev  <= irq_n;
            edge_hold <= fall_now | (edge_hold & ~ack);
        end
    end

    assign irq_req = edge_sel ? (edge_hold | fall_now) : ~irq_n;

    // R9
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        edge_hold && !ack |=> edge_hold);

endmodule

// File: rtl/prio_select_reg.sv
module prio_select_reg
    import intr_pkg::*;
#(
    parameter logic [PSEL_W-1:0] RESET_CODE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PSEL_W-1:0] wdata,
    input  logic              i_mask,
    output logic [PSEL_W-1:0] psel_q
);
    always_ff @(posedge clk) begin
        if (rst)
            psel_q <= RESET_CODE;
        else if (we && i_mask)
            psel_q <= wdata;
    end

    // R7
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        we && !i_mask |=> $stable(psel_q));

    // R7
    open_write_chk: assert property (@(posedge clk) disable iff (rst)
        we && i_mask |=> psel_q == $past(wdata));

endmodule

// File: rtl/vector_arbiter.sv
module vector_arbiter
    import intr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_MASKABLE-1:0] mreq,
    input  logic [PSEL_W-1:0]       psel,
    input  logic                    i_mask,
    input  logic                    x_mask,
    input  logic                    xirq,
    input  logic                    swi,
    input  logic                    ill,
    output grant_t                  grant
);
    logic [NUM_MASKABLE-1:0] req_g;
    promo_t                  promo;
    src_e                    pick;
    logic                    pick_valid;
    grant_t                  nxt;

    assign promo = decode_psel(psel);

    always_comb begin
        req_g      = i_mask ? '0 : mreq;
        pick_valid = 1'b0;
        pick       = SRC_IRQ;
        for (int k = NUM_MASKABLE - 1; k >= 0; k--) begin
            if (req_g[k]) begin
                pick_valid = 1'b1;
                pick       = src_e'(k[SRC_W-1:0]);
            end
        end
        if (promo.hit && req_g[promo.idx]) begin
            pick_valid = 1'b1;
            pick       = src_e'({1'b0, promo.idx});
        end

        nxt = '0;
        if (ill) begin
            nxt.valid = 1'b1;
            nxt.src   = SRC_ILLOP;
        end else if (swi) begin
            nxt.valid = 1'b1;
            nxt.src   = SRC_SWI;
        end else if (xirq && !x_mask) begin
            nxt.valid = 1'b1;
            nxt.src   = SRC_XIRQ;
        end else if (pick_valid) begin
            nxt.valid = 1'b1;
            nxt.src   = pick;
        end
        if (nxt.valid)
            nxt.vec = vector_of(nxt.src);
    end

    always_ff @(posedge clk) begin
        if (rst)
            grant <= '0;
        else
            grant <= nxt;
    end

    // R4
    illop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ill |=> grant.valid && grant.src == SRC_ILLOP);

    // R2
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        i_mask && !ill && !swi && !(xirq && !x_mask) |=> !grant.valid);

    // R3
    vec_form_chk: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> grant.vec[15:6] == 10'h3FF && !grant.vec[0]);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !grant.valid |-> grant.src == SRC_IRQ && grant.vec == '0);

endmodule

// File: rtl/intr_vector_resolver.sv
module intr_vector_resolver
    import intr_pkg::*;
#(
    parameter logic [3:0] PSEL_RESET = 4'b0101
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_n,
    input  logic        irq_edge_sel,
    input  logic        irq_ack,
    input  logic [13:0] periph_pend,
    input  logic [13:0] periph_en,
    input  logic        i_mask,
    input  logic        x_mask,
    input  logic        xirq_req,
    input  logic        swi_req,
    input  logic        illop_req,
    input  logic        psel_we,
    input  logic [3:0]  psel_wdata,
    output logic [3:0]  psel_q,
    output logic        grant_valid,
    output logic [4:0]  grant_src,
    output logic [15:0] grant_vec
);
    logic [NUM_MASKABLE-1:0] mreq;
    logic                    pin_req;
    grant_t                  grant;

    irq_qualifier u_pin (
        .clk      (clk),
        .rst      (rst),
        .irq_n    (irq_n),
        .edge_sel (irq_edge_sel),
        .ack      (irq_ack),
        .irq_req  (pin_req)
    );

    prio_select_reg #(.RESET_CODE(PSEL_RESET)) u_psel (
        .clk    (clk),
        .rst    (rst),
        .we     (psel_we),
        .wdata  (psel_wdata),
        .i_mask (i_mask),
        .psel_q (psel_q)
    );

    assign mreq[0] = pin_req;
    for (genvar g = 1; g < NUM_MASKABLE; g++) begin : g_periph
        assign mreq[g] = periph_pend[g-1] & periph_en[g-1];
    end

    vector_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .mreq   (mreq),
        .psel   (psel_q),
        .i_mask (i_mask),
        .x_mask (x_mask),
        .xirq   (xirq_req),
        .swi    (swi_req),
        .ill    (illop_req),
        .grant  (grant)
    );

    assign grant_valid = grant.valid;
    assign grant_src   = grant.src;
    assign grant_vec   = grant.vec;

endmodule

// File: tb/intr_vector_resolver_test.sv
module intr_vector_resolver_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_n = 1'b1;
    logic        irq_edge_sel = 1'b0;
    logic        irq_ack = 1'b0;
    logic [13:0] periph_pend = '0;
    logic [13:0] periph_en = '0;
    logic        i_mask = 1'b0;
    logic        x_mask = 1'b0;
    logic        xirq_req = 1'b0;
    logic        swi_req = 1'b0;
    logic        illop_req = 1'b0;
    logic        psel_we = 1'b0;
    logic [3:0]  psel_wdata = '0;
    logic [3:0]  psel_q;
    logic        grant_valid;
    logic [4:0]  grant_src;
    logic [15:0] grant_vec;

    int checks = 0;
    int failures = 0;

    logic [3:0] psel_m;
    logic       latch_m;
    logic       prev_m;

    always #5 clk = ~clk;

    intr_vector_resolver uut (
        .clk(clk), .rst(rst), .irq_n(irq_n), .irq_edge_sel(irq_edge_sel),
        .irq_ack(irq_ack), .periph_pend(periph_pend), .periph_en(periph_en),
        .i_mask(i_mask), .x_mask(x_mask), .xirq_req(xirq_req),
        .swi_req(swi_req), .illop_req(illop_req), .psel_we(psel_we),
        .psel_wdata(psel_wdata), .psel_q(psel_q), .grant_valid(grant_valid),
        .grant_src(grant_src), .grant_vec(grant_vec)
    );

    function automatic int promoted(input logic [3:0] code);
        case (code)
            4'd0: return 10;
            4'd1: return 11;
            4'd2: return 12;
            4'd3: return 13;
            4'd4: return 14;
            4'd5: return -1;
            default: return int'(code) - 6;
        endcase
    endfunction

    function automatic logic [15:0] exp_vector(input int id);
        if (id == 17) return 16'hFFF8;
        if (id == 16) return 16'hFFF6;
        if (id == 15) return 16'hFFF4;
        return 16'hFFD6 + 16'((14 - id) * 2);
    endfunction

    task automatic quiet();
        irq_n = 1'b1; irq_ack = 1'b0; periph_pend = '0; periph_en = '0;
        i_mask = 1'b0; x_mask = 1'b0; xirq_req = 1'b0; swi_req = 1'b0;
        illop_req = 1'b0; psel_we = 1'b0; psel_wdata = '0;
    endtask

    task automatic step(input string tag);
        logic        fall, pin_rq, ev;
        logic [14:0] req;
        logic [4:0]  es;
        logic [15:0] evec;
        int win, p;
        fall   = prev_m && !irq_n;
        pin_rq = irq_edge_sel ? (latch_m || fall) : !irq_n;
        req    = {periph_pend & periph_en, pin_rq};
        if (i_mask) req = '0;
        win = -1;
        if (illop_req) win = 17;
        else if (swi_req) win = 16;
        else if (xirq_req && !x_mask) win = 15;
        else begin
            p = promoted(psel_m);
            if (p >= 0 && req[p]) win = p;
            else for (int k = 14; k >= 0; k--) if (req[k]) win = k;
        end
        ev   = (win >= 0);
        es   = ev ? win[4:0] : 5'd0;
        evec = ev ? exp_vector(win) : 16'd0;
        latch_m = fall || (latch_m && !irq_ack);
        prev_m  = irq_n;
        if (psel_we && i_mask) psel_m = psel_wdata;
        @(posedge clk);
        #2;
        checks++;
        if (grant_valid !== ev || grant_src !== es || grant_vec !== evec || psel_q !== psel_m) begin
            failures++;
            $display("FAIL %s: got valid=%0b src=%0d vec=%h psel=%h, expected valid=%0b src=%0d vec=%h psel=%h",
                     tag, grant_valid, grant_src, grant_vec, psel_q, ev, es, evec, psel_m);
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        psel_m = 4'b0101; latch_m = 1'b0; prev_m = 1'b1;
        // R6 R10: reset state
        checks++;
        if (psel_q !== 4'b0101 || grant_valid !== 1'b0 || grant_src !== 5'd0 || grant_vec !== 16'd0) begin
            failures++;
            $display("FAIL R6 reset: got psel=%h valid=%0b src=%0d vec=%h, expected psel=5 valid=0 src=0 vec=0",
                     psel_q, grant_valid, grant_src, grant_vec);
        end

        // R1: everything pending, pin idle -> real-time tick
        quiet(); periph_pend = '1; periph_en = '1; step("R1 all pending");
        // R1 R3: accumulator edge beats SCI
        quiet(); periph_pend[11] = 1'b1; periph_pend[13] = 1'b1; periph_en = '1; step("R1 R3 paedge over sci");
        // R2: disabled capture ignored, SPI wins
        quiet(); periph_pend[1] = 1'b1; periph_pend[12] = 1'b1; periph_en[12] = 1'b1; step("R2 local enable");
        // R2: I bit masks all maskable
        quiet(); periph_pend = '1; periph_en = '1; irq_n = 1'b0; i_mask = 1'b1; step("R2 i mask");
        // R8: level pin wins over peripherals
        quiet(); periph_pend = '1; periph_en = '1; irq_n = 1'b0; step("R8 level low");
        quiet(); irq_n = 1'b0; step("R8 level held");
        // R4: non-maskable ordering, ignores I
        quiet(); i_mask = 1'b1; illop_req = 1'b1; swi_req = 1'b1; xirq_req = 1'b1; step("R4 illop first");
        quiet(); i_mask = 1'b1; swi_req = 1'b1; xirq_req = 1'b1; periph_pend = '1; periph_en = '1; step("R4 swi second");
        quiet(); xirq_req = 1'b1; periph_pend = '1; periph_en = '1; step("R4 xirq over maskable");
        quiet(); xirq_req = 1'b1; x_mask = 1'b1; step("R4 x mask blocks");
        // R7: write with I clear ignored, then with I set accepted
        quiet(); psel_we = 1'b1; psel_wdata = 4'hF; step("R7 locked write");
        quiet(); i_mask = 1'b1; psel_we = 1'b1; psel_wdata = 4'hF; step("R7 open write");
        // R5: code 15 promotes capture-4/compare-5 above pin and tick
        quiet(); periph_pend[0] = 1'b1; periph_pend[8] = 1'b1; periph_en = '1; irq_n = 1'b0; step("R5 promote oc5");
        quiet(); i_mask = 1'b1; psel_we = 1'b1; psel_wdata = 4'h0; step("R5 write code0");
        quiet(); periph_pend = '1; periph_en = '1; step("R5 promote tov");
        // R6: code 0101 restores default order
        quiet(); i_mask = 1'b1; psel_we = 1'b1; psel_wdata = 4'h5; step("R6 write 0101");
        quiet(); periph_pend[0] = 1'b1; periph_pend[8] = 1'b1; periph_en = '1; step("R6 default order");
        // R9: falling-edge mode
        quiet(); irq_edge_sel = 1'b1; step("R9 idle high");
        quiet(); irq_n = 1'b0; step("R9 fall");
        quiet(); irq_n = 1'b0; step("R9 held latched");
        quiet(); irq_n = 1'b0; irq_ack = 1'b1; step("R9 ack cycle");
        quiet(); irq_n = 1'b0; step("R9 low no new edge");
        quiet(); irq_n = 1'b1; step("R9 release");
        quiet(); irq_n = 1'b0; step("R9 second fall");
        quiet(); irq_n = 1'b1; step("R9 pulse gone still latched");
        quiet(); irq_ack = 1'b1; step("R9 ack after pulse");
        quiet(); step("R9 cleared");
        irq_edge_sel = 1'b0;

        // Random mix: R1 R2 R4 R5 R7 R8 R9 R10
        for (int n = 0; n < 4000; n++) begin
            periph_pend = 14'($urandom) & 14'($urandom);
            periph_en   = 14'($urandom) | 14'($urandom);
            i_mask      = ($urandom % 4) == 0;
            x_mask      = ($urandom % 2) == 0;
            illop_req   = ($urandom % 24) == 0;
            swi_req     = ($urandom % 20) == 0;
            xirq_req    = ($urandom % 10) == 0;
            irq_n       = ($urandom % 3) != 0;
            irq_ack     = ($urandom % 4) == 0;
            psel_we     = ($urandom % 6) == 0;
            psel_wdata  = 4'($urandom);
            if (($urandom % 50) == 0) irq_edge_sel = ~irq_edge_sel;
            step("R1 R5 R9 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule